// File: doc/BRIEF.md
# Synchronized Counter Group Write Logic

This block holds a bank of up-counters, five channels of 16 bits by default. Each channel has a run bit, and each counts up by one per clock while its run bit is set. A channel can also be placed in a synchronized group. Any bus write to a member of the group, whether a byte or a word, produces one full-width value. The addressed counter's own bytes fill the lanes the write does not enable. That merged value is then loaded into every member of the group on the same edge. Counters outside the group are written one byte lane at a time.

A two-bit combination-mode register selects plain counting or one of two PWM pairings. A guard protects this register. A mode write is refused while either of the two paired channels (3 and 4 by default) is running. A write that would move directly from one PWM pairing to the other is also refused. A refused write leaves the register unchanged and sets a sticky error flag, which software clears by writing a one to it.

Top module: `sync_cnt_bank`

## Requirements
- R1: After reset every counter, run bit, group bit, the mode register and the error flag read zero.
- R2: Address map. Addresses 0..4 select counters 0..4. Address 5 holds the run bits in data[4:0]. Address 6 holds the group bits in data[4:0]. Address 7 holds the mode in data[1:0], and writing data[15]=1 clears the error flag. Register fields are written only when be[0] is set, except the error clear, which needs be[1].
- R3: A write to a counter outside the group updates only its enabled byte lanes: be[1] for bits 15:8 and be[0] for bits 7:0. No other counter changes.
- R4: A byte write to a group member loads every group member with the addressed counter's post-write value. The enabled byte comes from the bus and the other byte is the addressed counter's own. Channels outside the group are not changed.
- R5: A word write to a group member loads the full data word into every group member.
- R6: A bus write to a counter takes priority over its increment on the same edge.
- R7: A counter whose run bit is set adds one on every clock and wraps from 0xFFFF to 0x0000. A counter whose run bit is clear holds its value.
- R8: Mode encoding: 00 or 01 is normal, 10 is complementary PWM and 11 is reset-synchronized PWM. A legal mode write appears on mode_o after one edge.
- R9: A mode write while counter 3 or 4 is running is refused: the mode is unchanged and the error flag is set.
- R10: A mode write from 10 to 11 or from 11 to 10 is refused and sets the error flag. Passing through a normal code first is accepted.
- R11: The error flag stays set until a write of data[15]=1 with be[1] to address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_be_i | input | 2 | Byte enables, bit 1 is the upper byte |
| wr_data_i | input | 16 | Write data |
| cnt_o | output | 80 | Counter values, channel n at bits 16n+15:16n |
| mode_o | output | 2 | Combination-mode register |
| mode_err_o | output | 1 | Sticky refused-mode-write flag |

## Verification
Group membership is not visible at the ports. A wrong group bit therefore shows up as a counter that, one edge after a write to some other channel, either takes a value it should not or misses one. Writes to one channel are followed by checks on its group partners and on a channel outside the group. A wrong byte merge shows up in the same cycle as the wrong byte in every group member, so each byte lane is written separately over counters that hold different starting values. The guard's state is visible directly on mode_o and mode_err_o one edge after each attempted write.

// File: rtl/sync_cnt_pkg.sv
package sync_cnt_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_NORMAL_B = 2'b01,
    MODE_CPWM     = 2'b10,
    MODE_RPWM     = 2'b11
  } mode_e;

  localparam int unsigned ERR_CLR_BIT = 15;
endpackage

// File: rtl/sync_cnt_channel.sv
module sync_cnt_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;   // write beats increment
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_load_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(load_val_i));
  p_inc_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc_i) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/sync_cnt_wr_merge.sv
module sync_cnt_wr_merge #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned BYTES = CNT_W / 8
) (
  input  logic [NUM_CH*CNT_W-1:0] cnt_i,
  input  logic [NUM_CH-1:0]       hit_i,
  input  logic [BYTES-1:0]        be_i,
  input  logic [CNT_W-1:0]        data_i,
  output logic [CNT_W-1:0]        merged_o
);
  logic [CNT_W-1:0] sel;

  // one-hot select of the addressed counter
  always_comb begin
    sel = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (hit_i[c]) sel |= cnt_i[c*CNT_W +: CNT_W];
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign merged_o[b*8 +: 8] = be_i[b] ? data_i[b*8 +: 8] : sel[b*8 +: 8];
  end
endmodule

// File: rtl/sync_cnt_mode_guard.sv
module sync_cnt_mode_guard
  import sync_cnt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wr_mode_i,
  input  logic       clr_i,
  input  logic       busy_i,
  output logic [1:0] mode_o,
  output logic       err_o
);
  mode_e mode_q;
  logic  err_q;
  logic  swap, reject;

  // direct PWM-to-PWM change: both upper bits set, lower bit differs
  assign swap   = mode_q[1] && wr_mode_i[1] && (mode_q[0] != wr_mode_i[0]);
  assign reject = wr_i && (busy_i || swap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORMAL;
      err_q  <= 1'b0;
    end else begin
      if (wr_i && !reject) mode_q <= mode_e'(wr_mode_i);
      if (reject)          err_q  <= 1'b1;   // set beats clear
      else if (clr_i)      err_q  <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_i) |=> ($stable(mode_o) && err_o));
  p_no_pwm_swap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o[1]) && mode_o[1]) |-> mode_o == $past(mode_o));
  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);
endmodule

// File: rtl/sync_cnt_bank.sv
module sync_cnt_bank
  import sync_cnt_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 16,
  parameter logic [NUM_CH-1:0] GUARD_MASK = 5'b11000,
  localparam int unsigned BYTES  = CNT_W / 8,
  localparam int unsigned ADDR_W = $clog2(NUM_CH + 3)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [BYTES-1:0]        wr_be_i,
  input  logic [CNT_W-1:0]        wr_data_i,
  output logic [NUM_CH*CNT_W-1:0] cnt_o,
  output logic [1:0]              mode_o,
  output logic                    mode_err_o
);
  localparam int unsigned START_ADDR = NUM_CH;
  localparam int unsigned SYNC_ADDR  = NUM_CH + 1;
  localparam int unsigned MODE_ADDR  = NUM_CH + 2;

  logic [NUM_CH-1:0] start_q, sync_q, hit, load;
  logic [CNT_W-1:0]  merged;
  logic              sync_hit, start_wr, sync_wr, mode_wr, err_clr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign hit[c] = wr_en_i && (wr_addr_i == ADDR_W'(c));
  end

  assign sync_hit = |(hit & sync_q);
  assign load     = hit | ({NUM_CH{sync_hit}} & sync_q);
  assign start_wr = wr_en_i && wr_addr_i == ADDR_W'(START_ADDR) && wr_be_i[0];
  assign sync_wr  = wr_en_i && wr_addr_i == ADDR_W'(SYNC_ADDR)  && wr_be_i[0];
  assign mode_wr  = wr_en_i && wr_addr_i == ADDR_W'(MODE_ADDR)  && wr_be_i[0];
  assign err_clr  = wr_en_i && wr_addr_i == ADDR_W'(MODE_ADDR)  && wr_be_i[BYTES-1]
                    && wr_data_i[ERR_CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      sync_q  <= '0;
    end else begin
      if (start_wr) start_q <= wr_data_i[NUM_CH-1:0];
      if (sync_wr)  sync_q  <= wr_data_i[NUM_CH-1:0];
    end
  end

  sync_cnt_wr_merge #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) merge_i (
    .cnt_i    (cnt_o),
    .hit_i    (hit),
    .be_i     (wr_be_i),
    .data_i   (wr_data_i),
    .merged_o (merged)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sync_cnt_channel #(.CNT_W(CNT_W)) ch_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load[c]),
      .load_val_i (merged),
      .inc_i      (start_q[c]),
      .cnt_o      (cnt_o[c*CNT_W +: CNT_W])
    );

    p_group_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_hit && sync_q[c]) |=> cnt_o[c*CNT_W +: CNT_W] == $past(merged));
    p_outsider_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !hit[c] && !(sync_hit && sync_q[c]) && !start_q[c])
        |=> $stable(cnt_o[c*CNT_W +: CNT_W]));
  end

  sync_cnt_mode_guard guard_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (mode_wr),
    .wr_mode_i (wr_data_i[1:0]),
    .clr_i     (err_clr),
    .busy_i    (|(start_q & GUARD_MASK)),
    .mode_o    (mode_o),
    .err_o     (mode_err_o)
  );

  p_onehot_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: tb/sync_cnt_bank_tb.sv
module sync_cnt_bank_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic [79:0] cnt;
  logic [1:0]  mode;
  logic        err;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sync_cnt_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_be_i(wr_be), .wr_data_i(wr_data), .cnt_o(cnt), .mode_o(mode),
    .mode_err_o(err)
  );

  function automatic logic [15:0] ch(int n);
    return cnt[n*16 +: 16];
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at negedge, one posedge, sample at following negedge
  task automatic bus_wr(logic [2:0] a, logic [1:0] be, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic tick(int k);
    for (int i = 0; i < k; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic t_reset;
    for (int c = 0; c < 5; c++) check("R1 counter", ch(c), 16'h0);
    check("R1 mode", 16'(mode), 16'h0);
    check("R1 err", 16'(err), 16'h0);
    tick(2);
    check("R1 run bits clear", ch(0), 16'h0);
  endtask

  task automatic t_individual;
    bus_wr(3'd2, 2'b11, 16'h1234);
    check("R2 word to ch2", ch(2), 16'h1234);
    bus_wr(3'd2, 2'b10, 16'hAB00);
    check("R3 upper lane", ch(2), 16'hAB34);
    bus_wr(3'd2, 2'b01, 16'h00CD);
    check("R3 lower lane", ch(2), 16'hABCD);
    check("R3 ch1 untouched", ch(1), 16'h0);
  endtask

  task automatic t_sync_byte;
    bus_wr(3'd2, 2'b11, 16'h1111);
    bus_wr(3'd3, 2'b11, 16'h2233);
    bus_wr(3'd6, 2'b01, 16'h000C);
    bus_wr(3'd2, 2'b10, 16'hA500);
    check("R4 upper to ch2: ch2", ch(2), 16'hA511);
    check("R4 upper to ch2: ch3", ch(3), 16'hA511);
    bus_wr(3'd2, 2'b11, 16'hC0DE);
    bus_wr(3'd3, 2'b10, 16'h2200);
    bus_wr(3'd2, 2'b01, 16'h0044);
    bus_wr(3'd3, 2'b01, 16'h007E);
    check("R4 lower to ch3: ch3", ch(3), 16'h227E);
    check("R4 lower to ch3: ch2", ch(2), 16'h227E);
    check("R4 outsider ch0", ch(0), 16'h0);
  endtask

  task automatic t_sync_word;
    bus_wr(3'd3, 2'b11, 16'hBEEF);
    check("R5 word ch2", ch(2), 16'hBEEF);
    check("R5 word ch3", ch(3), 16'hBEEF);
    check("R5 outsider ch4", ch(4), 16'h0);
    bus_wr(3'd4, 2'b11, 16'h0F0F);
    check("R3 outsider write ch4", ch(4), 16'h0F0F);
    check("R3 group unaffected", ch(2), 16'hBEEF);
  endtask

  task automatic t_count;
    bus_wr(3'd5, 2'b01, 16'h0001);
    check("R7 start edge", ch(0), 16'h0000);
    tick(10);
    check("R7 ten counts", ch(0), 16'd10);
    bus_wr(3'd0, 2'b11, 16'h1234);
    check("R6 write beats inc", ch(0), 16'h1234);
    bus_wr(3'd5, 2'b01, 16'h0000);
    check("R7 last inc", ch(0), 16'h1235);
    tick(3);
    check("R7 stopped holds", ch(0), 16'h1235);
    bus_wr(3'd1, 2'b11, 16'hFFFF);
    bus_wr(3'd5, 2'b01, 16'h0002);
    check("R7 pre-wrap", ch(1), 16'hFFFF);
    tick(1);
    check("R7 wrap", ch(1), 16'h0000);
    bus_wr(3'd5, 2'b01, 16'h0000);
    check("R7 after wrap", ch(1), 16'h0001);
  endtask

  task automatic t_sync_count;
    bus_wr(3'd5, 2'b01, 16'h000C);
    tick(5);
    check("R7 group count ch2", ch(2), 16'hBEEF + 16'd5);
    check("R7 group count ch3", ch(3), 16'hBEEF + 16'd5);
    bus_wr(3'd3, 2'b11, 16'h0100);
    check("R6 group write while running", ch(2), 16'h0100);
    bus_wr(3'd5, 2'b01, 16'h0000);
    check("R7 group stop ch3", ch(3), 16'h0101);
    bus_wr(3'd6, 2'b01, 16'h0000);
  endtask

  task automatic t_mode;
    bus_wr(3'd5, 2'b01, 16'h0010);
    bus_wr(3'd7, 2'b01, 16'h0003);
    check("R9 busy refused mode", 16'(mode), 16'h0);
    check("R9 busy err", 16'(err), 16'h1);
    bus_wr(3'd5, 2'b01, 16'h0000);
    check("R11 sticky", 16'(err), 16'h1);
    bus_wr(3'd7, 2'b10, 16'h8000);
    check("R11 cleared", 16'(err), 16'h0);
    bus_wr(3'd7, 2'b01, 16'h0003);
    check("R8 to rpwm", 16'(mode), 16'h3);
    check("R8 no err", 16'(err), 16'h0);
    bus_wr(3'd7, 2'b01, 16'h0002);
    check("R10 swap refused", 16'(mode), 16'h3);
    check("R10 swap err", 16'(err), 16'h1);
    bus_wr(3'd7, 2'b10, 16'h8000);
    bus_wr(3'd7, 2'b01, 16'h0001);
    check("R10 to normal", 16'(mode), 16'h1);
    bus_wr(3'd7, 2'b01, 16'h0002);
    check("R8 to cpwm", 16'(mode), 16'h2);
    check("R8 err clear", 16'(err), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_individual();
    t_sync_byte();
    t_sync_word();
    t_count();
    t_sync_count();
    t_mode();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule